// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of a set-associative cache is overwritten when a miss must be filled. The cache presents the set it is looking up together with a valid bit and a dirty bit for every way of that set. The block replies, within the same cycle, with the number of the way to replace. Separately, the cache reports every hit and every fill as a "touch" of one way in one set. The block uses these touches to keep, for each set, a complete ordering of its ways from most recently used to least recently used.

A build-time parameter selects the replacement rule. In least-recently-used mode the oldest way is replaced. In random mode the choice comes from a free-running linear feedback shift register. In clean-first mode the block avoids a write-back where it can: it prefers ways that are not dirty, and recency breaks ties among them. In every mode an empty (invalid) way is filled before any occupied way is displaced. Tag storage and write-back sequencing belong to the surrounding cache.

Top module: `victim_way_selector`

## Requirements
- R1: When any way of the looked-up set has its valid bit at 0, the victim is the lowest-numbered such way, regardless of policy (bit i of a valid or dirty vector belongs to way i).
- R2: In LRU mode with all ways valid, the victim is the way of the looked-up set whose age is NUM_WAYS-1 (the oldest).
- R3: Each way of each set has an age in 0..NUM_WAYS-1, where 0 means most recent, and the ages of a set are always distinct. A touch sets the touched way's age to 0 and adds one to every way of that set that was younger than it. Other sets and untouched ways do not change, and without a touch no age changes.
- R4: In clean-first mode with all ways valid, the victim is the oldest way whose dirty bit is 0. If every way is dirty, the oldest way is chosen.
- R5: In random mode with all ways valid, the victim is the register value modulo NUM_WAYS. The register is a 16-bit right-shifting Galois register with feedback mask 0xB400. It is loaded with 1 in reset and steps once on every clock edge outside reset.
- R6: The random register never holds zero.
- R7: The victim depends combinationally on the lookup inputs and the current state, and is always below NUM_WAYS.
- R8: Reset gives way i of every set age i, so way NUM_WAYS-1 is the first LRU victim of a fully valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_set | input | $clog2(NUM_SETS) | Set being looked up for a fill |
| way_valid | input | NUM_WAYS | Valid bit for each way of the looked-up set |
| way_dirty | input | NUM_WAYS | Dirty bit for each way of the looked-up set |
| touch_en | input | 1 | A hit or fill occurred this cycle |
| touch_set | input | $clog2(NUM_SETS) | Set of the hit or fill |
| touch_way | input | $clog2(NUM_WAYS) | Way of the hit or fill |
| victim_way | output | $clog2(NUM_WAYS) | Way to replace in the looked-up set |

## Verification
On every cycle, the assertions check the following:
- the victim is in range;
- empty ways are chosen first, with the lowest number winning;
- an LRU victim is the oldest way;
- a clean-first victim is clean whenever a clean way exists;
- each set's ages stay a permutation;
- a touched way becomes youngest on the next cycle;
- the random register is never zero.

Only the bench scenarios can show the exact aging sequence under a series of touches, and that touching one set leaves the others alone. The same holds for re-touching the youngest way being a no-op, for the exact random sequence, and for reset restoring the initial order.

// File: rtl/vws_pkg.sv
package vws_pkg;

    typedef enum logic [1:0] {
        POL_LRU    = 2'd0,
        POL_RANDOM = 2'd1,
        POL_CLEAN  = 2'd2
    } policy_e;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_MASK = 16'hB400;
    localparam logic [15:0] RND_SEED = 16'h0001;

    // One step of the right-shifting Galois register
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RND_MASK) : (s >> 1);
    endfunction

endpackage

// File: rtl/vws_age_table.sv
module vws_age_table #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SW = $clog2(NUM_SETS),
    localparam int WW = $clog2(NUM_WAYS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   touch_en,
    input  logic [SW-1:0]                          touch_set,
    input  logic [WW-1:0]                          touch_way,
    output logic [NUM_SETS-1:0][NUM_WAYS-1:0][WW-1:0] ages
);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [NUM_WAYS-1:0][WW-1:0] age_q;
        logic                        hit_set;

        assign hit_set = touch_en && (touch_set == SW'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    age_q[w] <= WW'(w);
                end
            end else if (hit_set) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (WW'(w) == touch_way) begin
                        age_q[w] <= '0;
                    end else if (age_q[w] < age_q[touch_way]) begin
                        age_q[w] <= age_q[w] + 1'b1;
                    end
                end
            end
        end

        assign ages[s] = age_q;
    end

endmodule

// File: rtl/vws_rnd_gen.sv
module vws_rnd_gen
    import vws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [RND_W-1:0] rnd
);

    always_ff @(posedge clk) begin
        if (rst) rnd <= RND_SEED;
        else     rnd <= rnd_step(rnd);
    end

endmodule

// File: rtl/vws_pick.sv
module vws_pick
    import vws_pkg::*;
#(
    parameter int      NUM_WAYS = 4,
    parameter policy_e POLICY   = POL_LRU,
    localparam int WW = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][WW-1:0] set_ages,
    input  logic [NUM_WAYS-1:0]         valid,
    input  logic [NUM_WAYS-1:0]         dirty,
    input  logic [RND_W-1:0]            rnd,
    output logic [WW-1:0]               victim
);

    logic          inv_found;
    logic [WW-1:0] inv_way;
    logic [WW-1:0] lru_way;
    logic          clean_found;
    logic [WW-1:0] clean_way;
    logic [WW-1:0] clean_age;
    logic [WW-1:0] rnd_way;
    logic [WW-1:0] pol_way;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WW'(w);
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (set_ages[w] == WW'(NUM_WAYS - 1)) lru_way = WW'(w);
        end
    end

    always_comb begin
        clean_found = 1'b0;
        clean_way   = '0;
        clean_age   = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!dirty[w] && (!clean_found || set_ages[w] > clean_age)) begin
                clean_found = 1'b1;
                clean_way   = WW'(w);
                clean_age   = set_ages[w];
            end
        end
    end

    assign rnd_way = WW'(32'(rnd) % NUM_WAYS);

    always_comb begin
        unique case (POLICY)
            POL_RANDOM: pol_way = rnd_way;
            POL_CLEAN:  pol_way = clean_found ? clean_way : lru_way;
            default:    pol_way = lru_way;
        endcase
    end

    assign victim = inv_found ? inv_way : pol_way;

endmodule

// File: rtl/victim_way_selector.sv
module victim_way_selector
    import vws_pkg::*;
#(
    parameter int      NUM_SETS = 8,
    parameter int      NUM_WAYS = 4,
    parameter policy_e POLICY   = POL_LRU,
    localparam int SW = $clog2(NUM_SETS),
    localparam int WW = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SW-1:0]       lookup_set,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_dirty,
    input  logic                touch_en,
    input  logic [SW-1:0]       touch_set,
    input  logic [WW-1:0]       touch_way,
    output logic [WW-1:0]       victim_way
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][WW-1:0] all_ages;
    logic [RND_W-1:0]                         rnd_state;

    vws_age_table #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_ages (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way),
        .ages      (all_ages)
    );

    vws_rnd_gen u_rnd (
        .clk (clk),
        .rst (rst),
        .rnd (rnd_state)
    );

    vws_pick #(.NUM_WAYS(NUM_WAYS), .POLICY(POLICY)) u_pick (
        .set_ages (all_ages[lookup_set]),
        .valid    (way_valid),
        .dirty    (way_dirty),
        .rnd      (rnd_state),
        .victim   (victim_way)
    );

endmodule

// File: rtl/vws_checker.sv
module vws_checker
    import vws_pkg::*;
#(
    parameter int      NUM_SETS = 8,
    parameter int      NUM_WAYS = 4,
    parameter policy_e POLICY   = POL_LRU,
    localparam int SW = $clog2(NUM_SETS),
    localparam int WW = $clog2(NUM_WAYS)
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic [SW-1:0]                            lookup_set,
    input logic [NUM_WAYS-1:0]                      way_valid,
    input logic [NUM_WAYS-1:0]                      way_dirty,
    input logic                                     touch_en,
    input logic [SW-1:0]                            touch_set,
    input logic [WW-1:0]                            touch_way,
    input logic [WW-1:0]                            victim_way,
    input logic [NUM_SETS-1:0][NUM_WAYS-1:0][WW-1:0] ages,
    input logic [RND_W-1:0]                         rnd
);

    logic [NUM_WAYS-1:0] below_mask;
    logic                perm_ok;
    logic                t_en_q;
    logic [SW-1:0]       t_set_q;
    logic [WW-1:0]       t_way_q;

    assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

    always_comb begin
        perm_ok = 1'b1;
        for (int s = 0; s < NUM_SETS; s++) begin
            logic [NUM_WAYS-1:0] seen;
            seen = '0;
            for (int w = 0; w < NUM_WAYS; w++) seen[ages[s][w]] = 1'b1;
            if (!(&seen)) perm_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_en_q  <= 1'b0;
            t_set_q <= '0;
            t_way_q <= '0;
        end else begin
            t_en_q  <= touch_en;
            t_set_q <= touch_set;
            t_way_q <= touch_way;
        end
    end

    assert_victim_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(victim_way) < NUM_WAYS);

    assert_invalid_first_R1: assert property (@(posedge clk) disable iff (rst)
        !(&way_valid) |-> (!way_valid[victim_way] && ((way_valid & below_mask) == below_mask)));

    assert_lru_oldest_R2: assert property (@(posedge clk) disable iff (rst)
        (POLICY == POL_LRU && (&way_valid)) |->
            ages[lookup_set][victim_way] == WW'(NUM_WAYS - 1));

    assert_clean_pref_R4: assert property (@(posedge clk) disable iff (rst)
        (POLICY == POL_CLEAN && (&way_valid) && !(&way_dirty)) |-> !way_dirty[victim_way]);

    assert_age_perm_R3: assert property (@(posedge clk) disable iff (rst)
        perm_ok);

    assert_touch_mru_R3: assert property (@(posedge clk) disable iff (rst)
        t_en_q |-> ages[t_set_q][t_way_q] == '0);

    assert_rnd_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        rnd != '0);

endmodule

bind victim_way_selector vws_checker #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .POLICY   (POLICY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lookup_set (lookup_set),
    .way_valid  (way_valid),
    .way_dirty  (way_dirty),
    .touch_en   (touch_en),
    .touch_set  (touch_set),
    .touch_way  (touch_way),
    .victim_way (victim_way),
    .ages       (all_ages),
    .rnd        (rnd_state)
);

// File: tb/victim_way_selector_tb.sv
module victim_way_selector_tb;
    import vws_pkg::*;

    localparam int S = 4;
    localparam int W = 4;

    typedef struct packed {
        logic       ten;
        logic [1:0] tset;
        logic [1:0] tway;
        logic [1:0] lset;
        logic [3:0] val;
        logic [3:0] dty;
        logic [1:0] exp_lru;
        logic [1:0] exp_cln;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 2'd1, 4'hF,    4'h0,    2'd3, 2'd3},
        '{1'b1, 2'd1, 2'd3, 2'd1, 4'hF,    4'b0100, 2'd2, 2'd1},
        '{1'b1, 2'd1, 2'd0, 2'd1, 4'hF,    4'hF,    2'd2, 2'd2},
        '{1'b1, 2'd1, 2'd2, 2'd1, 4'hF,    4'b0010, 2'd1, 2'd3},
        '{1'b1, 2'd1, 2'd2, 2'd1, 4'hF,    4'h0,    2'd1, 2'd1},
        '{1'b1, 2'd2, 2'd1, 2'd1, 4'hF,    4'b1011, 2'd1, 2'd2},
        '{1'b0, 2'd0, 2'd0, 2'd2, 4'hF,    4'h0,    2'd3, 2'd3},
        '{1'b0, 2'd0, 2'd0, 2'd1, 4'b1011, 4'h0,    2'd2, 2'd2},
        '{1'b0, 2'd0, 2'd0, 2'd1, 4'b0101, 4'h0,    2'd1, 2'd1},
        '{1'b0, 2'd0, 2'd0, 2'd1, 4'h0,    4'h0,    2'd0, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lookup_set = '0;
    logic [3:0] way_valid = 4'hF;
    logic [3:0] way_dirty = 4'h0;
    logic       touch_en = 1'b0;
    logic [1:0] touch_set = '0;
    logic [1:0] touch_way = '0;
    logic [1:0] v_lru, v_rnd, v_cln;
    logic [15:0] mdl;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    victim_way_selector #(.NUM_SETS(S), .NUM_WAYS(W), .POLICY(POL_LRU)) u_dut (
        .clk(clk), .rst(rst), .lookup_set(lookup_set), .way_valid(way_valid),
        .way_dirty(way_dirty), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .victim_way(v_lru));

    victim_way_selector #(.NUM_SETS(S), .NUM_WAYS(W), .POLICY(POL_RANDOM)) u_dut_rnd (
        .clk(clk), .rst(rst), .lookup_set(lookup_set), .way_valid(way_valid),
        .way_dirty(way_dirty), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .victim_way(v_rnd));

    victim_way_selector #(.NUM_SETS(S), .NUM_WAYS(W), .POLICY(POL_CLEAN)) u_dut_cln (
        .clk(clk), .rst(rst), .lookup_set(lookup_set), .way_valid(way_valid),
        .way_dirty(way_dirty), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .victim_way(v_cln));

    // Random register model from R5: shift right, xor 0xB400 when bit 0 was set
    always_ff @(posedge clk) begin
        if (rst) mdl <= 16'h0001;
        else     mdl <= mdl[0] ? ((mdl >> 1) ^ 16'hB400) : (mdl >> 1);
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd_expect(input logic [3:0] val);
        for (int w = 0; w < W; w++) if (!val[w]) return w;
        return int'(mdl) % W;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seen_mask;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R8: reset order makes way 3 the first LRU victim in every set
        for (int s = 0; s < S; s++) begin
            @(negedge clk);
            lookup_set = 2'(s);
            #1 check("R8 reset lru", int'(v_lru), 3);
        end

        // Vector table: touch then lookup, victims sampled after the edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            touch_en   = VECS[i].ten;
            touch_set  = VECS[i].tset;
            touch_way  = VECS[i].tway;
            lookup_set = VECS[i].lset;
            way_valid  = VECS[i].val;
            way_dirty  = VECS[i].dty;
            @(posedge clk);
            #1;
            touch_en = 1'b0;
            check($sformatf("R2/R3/R1 lru vec%0d", i), int'(v_lru), int'(VECS[i].exp_lru));
            check($sformatf("R4/R1 clean vec%0d", i), int'(v_cln), int'(VECS[i].exp_cln));
            check($sformatf("R5/R1 rnd vec%0d", i), int'(v_rnd), rnd_expect(VECS[i].val));
        end

        // R5: random sequence over many cycles, all ways valid; R3: no touch, no aging
        seen_mask = 0;
        @(negedge clk);
        way_valid  = 4'hF;
        way_dirty  = 4'h0;
        lookup_set = 2'd1;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk);
            #1;
            check("R5 rnd seq", int'(v_rnd), int'(mdl) % W);
            seen_mask |= (1 << v_rnd);
        end
        check("R5 rnd covers all ways", seen_mask, 15);
        check("R3 idle keeps order", int'(v_lru), 1);

        // R7: victim follows lookup inputs within the cycle
        @(negedge clk);
        way_valid = 4'b1110;
        #1 check("R7 comb invalid", int'(v_lru), 0);
        way_valid = 4'b0111;
        #1 check("R7 comb invalid hi", int'(v_cln), 3);
        way_valid = 4'hF;

        // R4: all dirty falls back to LRU in set 2 (oldest way 3)
        lookup_set = 2'd2;
        way_dirty  = 4'hF;
        #1 check("R4 all dirty", int'(v_cln), 3);
        way_dirty  = 4'b0111;
        #1 check("R4 only oldest clean", int'(v_cln), 3);
        way_dirty  = 4'b1000;
        #1 check("R4 oldest dirty skipped", int'(v_cln), 2);
        way_dirty  = 4'h0;

        // R8: reset restores initial order after touches
        lookup_set = 2'd1;
        touch_en = 1'b1; touch_set = 2'd1; touch_way = 2'd3;
        @(negedge clk);
        touch_en = 1'b0;
        #1 check("R3 touched not victim", int'(v_lru), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R8 re-reset lru", int'(v_lru), 3);
        check("R8 re-reset clean", int'(v_cln), 3);
        check("R6 rnd after reset", int'(v_rnd), 1);

        finish_run();
    end

endmodule